// File: doc/BRIEF.md
# Receive Frame Error Status Register

This block sits behind a receive MAC and classifies every completed frame. When the MAC signals the end of a frame, the block looks at the frame's byte count, the CRC check result and the number of residual bits. It also looks at the destination address class, the length/type field, whether a collision hit the station's own transmission, the loopback mode and the free space left in the receive buffer. From these it sets up to five sticky error and event flags.

The host reads the flags as one 8-bit status word and clears a flag by writing 1 to its bit. The flags also clear themselves when the next frame begins. A host-writable mask selects which flags drive the interrupt line.

Top module: `rx_err_status`

## Requirements
- R1: After reset, the status word and the interrupt mask are zero and `irq` is low.
- R2: At frame end, bit 4 (remote command) sets when all of these hold: the length/type field is 0x0900, remote detection is enabled, the short-accept enable is clear, and `dst_class` is 2'b01 (own physical address).
- R3: Bit 4 never sets for `dst_class` 2'b10 (multicast), 2'b11 (broadcast) or 2'b00 (no match), and never sets while short-accept is enabled.
- R4: At frame end, bit 3 (short frame) sets when the byte count is at most 60. While short-accept is enabled, the limit drops to 6.
- R5: A collision during the station's own transmission keeps bit 3 and bit 1 from setting for that frame.
- R6: At frame end, bit 1 (CRC error) sets whenever the CRC is bad, unless R5 applies.
- R7: At frame end, bit 2 (alignment error) sets when the CRC is bad and the residual bit count is nonzero.
- R8: At frame end, bit 0 (overflow) sets when the byte count exceeds the free buffer space, but never in loopback mode.
- R9: A status write clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R10: A frame-start pulse clears all five flags on the next clock edge.
- R11: If a frame-end set and a clear (host write or frame start) hit the same flag in the same cycle, the flag ends up set.
- R12: `irq` is high when any flag is set and its mask bit (same bit position, written through `mask_wr`) is 1. Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Pulse at start of a received frame |
| frm_end | input | 1 | Pulse at end of a received frame; frame fields valid |
| frm_len | input | LEN_W | Frame byte count (addresses, length field, data) |
| crc_ok | input | 1 | CRC check passed |
| bit_rem | input | 3 | Residual bits beyond the last full byte |
| dst_class | input | 2 | 00 none, 01 own address, 10 multicast, 11 broadcast |
| len_type | input | 16 | Received length/type field |
| own_tx_coll | input | 1 | Collision occurred during own transmission |
| loopback | input | 1 | Loopback mode active |
| buf_free | input | LEN_W | Free receive buffer space in bytes |
| rmt_det_en | input | 1 | Remote command detection enable |
| short_acc_en | input | 1 | Short-frame accept enable |
| st_wr | input | 1 | Host write to the status word (write 1 to clear) |
| mask_wr | input | 1 | Host write to the interrupt mask |
| host_wdata | input | 8 | Host write data |
| status | output | 8 | Status word; bits 7 to 5 read 0 |
| irq_mask | output | 8 | Interrupt mask readback; bits 7 to 5 read 0 |
| irq | output | 1 | Interrupt request |

## Verification
All state sits in two five-bit registers, so any fault in the set, clear or suppression logic shows on `status` one clock after the causing frame-end, write or frame-start pulse. A flag that sets wrongly or fails to clear also shows up on `irq` in that same cycle when its mask bit is on. The stimulus mixes random frames with directed cases. These cover the 60/6 byte limits, the 0x0900 field under every address class, and collisions, loopback and same-cycle set-versus-clear collisions. After every clock, the full status word and `irq` are compared with a bench model.

// File: rtl/rx_err_status.sv
module rx_err_status #(
  parameter int LEN_W         = 11,
  parameter int SHORT_MAX     = 60,
  parameter int SHORT_MAX_ACC = 6,
  parameter logic [15:0] RMT_CODE = 16'h0900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             crc_ok,
  input  logic [2:0]       bit_rem,
  input  logic [1:0]       dst_class,
  input  logic [15:0]      len_type,
  input  logic             own_tx_coll,
  input  logic             loopback,
  input  logic [LEN_W-1:0] buf_free,
  input  logic             rmt_det_en,
  input  logic             short_acc_en,
  input  logic             st_wr,
  input  logic             mask_wr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       status,
  output logic [7:0]       irq_mask,
  output logic             irq
);
  localparam logic [1:0] CLS_OWN = 2'b01;
  localparam logic [LEN_W-1:0] LIM_N = LEN_W'(SHORT_MAX);
  localparam logic [LEN_W-1:0] LIM_A = LEN_W'(SHORT_MAX_ACC);

  logic [4:0] flg_q, msk_q, set_v, clr_v;
  logic [LEN_W-1:0] short_lim;

  assign short_lim = short_acc_en ? LIM_A : LIM_N;

  assign set_v[4] = rmt_det_en && !short_acc_en && dst_class == CLS_OWN && len_type == RMT_CODE;
  assign set_v[3] = frm_len <= short_lim && !own_tx_coll;
  assign set_v[2] = !crc_ok && bit_rem != 3'd0;
  assign set_v[1] = !crc_ok && !own_tx_coll;
  assign set_v[0] = frm_len > buf_free && !loopback;

  assign clr_v = (st_wr ? host_wdata[4:0] : 5'd0) | {5{frm_start}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
      msk_q <= '0;
    end else begin
      flg_q <= (flg_q & ~clr_v) | (frm_end ? set_v : 5'd0);
      if (mask_wr) msk_q <= host_wdata[4:0];
    end
  end

  assign status   = {3'b000, flg_q};
  assign irq_mask = {3'b000, msk_q};
  assign irq      = |(flg_q & msk_q);

  // R3
  rmt_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[4]) |-> $past(frm_end && dst_class == CLS_OWN && !short_acc_en));
  // R7
  align_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[2]) |-> $past(frm_end && !crc_ok && bit_rem != 3'd0));
  // R8
  ovf_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[0]) |-> $past(frm_end && !loopback));
  // R5
  coll_supp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[1]) |-> $past(!own_tx_coll));
  // R9
  w1c_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && host_wdata[1] && !frm_end) |=> !status[1]);
  // R10
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !frm_end) |=> status[4:0] == 5'd0);
  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_mask[4:0] != 5'd0 && status[4:0] != 5'd0));
endmodule

// File: tb/rx_err_status_tb.sv
module rx_err_status_tb;
  localparam int LW = 11;
  logic clk = 0, rst_n = 0;
  logic frm_start = 0, frm_end = 0, crc_ok = 1, own_tx_coll = 0, loopback = 0;
  logic [LW-1:0] frm_len = 100, buf_free = 1000;
  logic [2:0] bit_rem = 0;
  logic [1:0] dst_class = 0;
  logic [15:0] len_type = 0;
  logic rmt_det_en = 0, short_acc_en = 0, st_wr = 0, mask_wr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] status, irq_mask;
  logic irq;
  int checks = 0, fails = 0;
  logic [4:0] exp_st = 0, exp_mk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_err_status #(.LEN_W(LW)) u_dut (
    .clk, .rst_n, .frm_start, .frm_end, .frm_len, .crc_ok, .bit_rem, .dst_class,
    .len_type, .own_tx_coll, .loopback, .buf_free, .rmt_det_en, .short_acc_en,
    .st_wr, .mask_wr, .host_wdata, .status, .irq_mask, .irq);

  function automatic logic [4:0] sets();
    logic [4:0] s;
    int lim = short_acc_en ? 6 : 60;
    s[4] = rmt_det_en && !short_acc_en && dst_class == 2'b01 && len_type == 16'h0900; // R2 R3
    s[3] = (int'(frm_len) <= lim) && !own_tx_coll;                                   // R4 R5
    s[2] = !crc_ok && bit_rem != 0;                                                   // R7
    s[1] = !crc_ok && !own_tx_coll;                                                   // R6 R5
    s[0] = (frm_len > buf_free) && !loopback;                                         // R8
    return s;
  endfunction

  function automatic string tag(int b);
    case (b)
      4: return "R2";
      3: return "R4";
      2: return "R7";
      1: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs set before call (at negedge); model, clock, compare
  task automatic step(string req);
    logic [4:0] clr;
    clr = (st_wr ? host_wdata[4:0] : 5'd0) | {5{frm_start}};
    exp_st = (exp_st & ~clr) | (frm_end ? sets() : 5'd0); // R9 R10 R11
    if (mask_wr) exp_mk = host_wdata[4:0];
    @(posedge clk); #1;
    for (int b = 0; b < 5; b++)
      chk(status[b] == exp_st[b], (req != "") ? req : tag(b), status, {3'b0, exp_st});
    chk(status[7:5] == 0 && irq_mask[7:5] == 0, "R12", status, {3'b0, exp_st});
    chk(irq_mask[4:0] == exp_mk, "R12", irq_mask, {3'b0, exp_mk});
    chk(irq == |(exp_st & exp_mk), "R12", {7'b0, irq}, {7'b0, |(exp_st & exp_mk)});
    @(negedge clk);
    frm_start = 0; frm_end = 0; st_wr = 0; mask_wr = 0;
  endtask

  task automatic frame(int len, bit crc, int rem, int cls, int lt, bit coll, string req);
    frm_end = 1; frm_len = LW'(len); crc_ok = crc; bit_rem = 3'(rem);
    dst_class = 2'(cls); len_type = 16'(lt); own_tx_coll = coll;
    step(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 0 && irq_mask == 0 && irq == 0, "R1", status, 8'h00);
    rst_n = 1;
    @(negedge clk);
    host_wdata = 8'hff; mask_wr = 1; step("R12");
    // R2 remote command on own address
    rmt_det_en = 1; frame(100, 1, 0, 1, 'h0900, 0, "R2");
    chk(status[4] == 1, "R2", status, 8'h10);
    // R3 suppression by class and short-accept
    for (int c = 0; c < 4; c += 2) begin
      frm_start = 1; step("R10");
      frame(100, 1, 0, c + 2 - c / 2 * 1 - 1 + 0, 'h0900, 0, "R3");
    end
    frm_start = 1; step("R10");
    frame(100, 1, 0, 3, 'h0900, 0, "R3");
    chk(status[4] == 0, "R3", status, 8'h00);
    frame(100, 1, 0, 0, 'h0900, 0, "R3");
    short_acc_en = 1; frame(100, 1, 0, 1, 'h0900, 0, "R3");
    chk(status[4] == 0, "R3", status, 8'h00);
    // R4 short limits
    short_acc_en = 0; frame(61, 1, 0, 1, 0, 0, "R4");
    chk(status[3] == 0, "R4", status, 8'h00);
    frame(60, 1, 0, 1, 0, 0, "R4");
    chk(status[3] == 1, "R4", status, 8'h08);
    frm_start = 1; step("R10");
    chk(status[4:0] == 0, "R10", status, 8'h00);
    short_acc_en = 1; frame(7, 1, 0, 1, 0, 0, "R4");
    frame(6, 1, 0, 1, 0, 0, "R4");
    short_acc_en = 0;
    // R5 collision suppression, R6 R7 crc/alignment
    frm_start = 1; step("R10");
    frame(20, 0, 3, 1, 0, 1, "R5");
    chk(status[3:1] == 3'b010, "R5", status, 8'h04);
    frame(200, 0, 0, 1, 0, 0, "R6");
    chk(status[2:1] == 2'b11, "R7", status, 8'h06);
    // R8 overflow and loopback
    frm_start = 1; step("R10");
    buf_free = 50; loopback = 1; frame(100, 1, 0, 1, 0, 0, "R8");
    loopback = 0; frame(100, 1, 0, 1, 0, 0, "R8");
    frame(50, 1, 0, 1, 0, 0, "R8");
    chk(status[0] == 1, "R8", status, 8'h09);
    buf_free = 1000;
    // R9 write-one-to-clear
    st_wr = 1; host_wdata = 8'h08; step("R9");
    chk(status[3] == 0 && status[0] == 1, "R9", status, 8'h01);
    // R11 set wins over host clear and frame start
    st_wr = 1; host_wdata = 8'h1f; frm_start = 1;
    frm_end = 1; frm_len = 30; crc_ok = 0; bit_rem = 1; own_tx_coll = 0;
    step("R11");
    chk(status[3:1] == 3'b111, "R11", status, 8'h0e);
    // R12 mask gating
    host_wdata = 8'h01; mask_wr = 1; step("R12");
    chk(irq == 0, "R12", {7'b0, irq}, 8'h00);
    // random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 8;
      frm_start = ($urandom % 6) == 0;
      frm_end = ($urandom % 3) == 0;
      frm_len = LW'(r < 3 ? $urandom % 10 : (r < 6 ? 55 + $urandom % 10 : $urandom % 1600));
      buf_free = LW'($urandom % 1600);
      crc_ok = $urandom % 2; bit_rem = 3'($urandom);
      dst_class = 2'($urandom); len_type = ($urandom % 2) ? 16'h0900 : 16'($urandom);
      own_tx_coll = ($urandom % 4) == 0; loopback = ($urandom % 4) == 0;
      rmt_det_en = $urandom % 2; short_acc_en = ($urandom % 3) == 0;
      st_wr = ($urandom % 4) == 0; mask_wr = ($urandom % 8) == 0;
      host_wdata = 8'($urandom);
      step("");
    end
    done = 1;
  end

  initial begin
    void'($urandom(1234));
    fork
      begin wait (done); end
      begin repeat (100000) @(posedge clk);
        checks++; fails++; $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule